// File: doc/BRIEF.md
# Processor Interrupt Level Arbiter

This block sits in front of a processor core and decides which interrupt level, if any, the core should take next. It merges a vector of external interrupt request lines with a software interrupt register. The two timer-match bits of that register are not treated as levels of their own. Either of them raises one fixed level instead. The block then discards every level that is not strictly above the core's current interrupt level and picks the highest one that remains.

The chosen level is turned into a trap type code: a parameterised base code with the level number placed in its low bits. That code and a request flag are presented to the core from registers. A request is withdrawn when nothing pending lies above the current level, or when interrupts are globally disabled. A new request is not raised while the core is already servicing a trap whose type is larger than the candidate.

A separate wake output pulses whenever any external line rises, so that a halted core can be restarted. A falling line only causes the selection to be evaluated again; it does not wake the core.

Top module: `irq_level_arbiter`

## Requirements
- R1: During and right after reset, `irq_req` is 0, `irq_tt` is 0 and `core_wake` is 0.
- R2: The pending level vector is `ext_req` ORed with bits 15..1 of `soft_reg`. Bit i of either source maps to level i. Bit 0 and bit 16 of `soft_reg` are never levels in their own right.
- R3: If `soft_reg` bit 0 (tick match) or bit 16 (system tick match) is set, level 14 is pending.
- R4: If no pending level is strictly greater than `cur_level`, then on the next cycle `irq_req` is 0 and `irq_tt` is 0, whatever the value of `int_en`.
- R5: With `int_en`=1, the highest pending level L above `cur_level` is chosen, and `irq_tt` becomes `TT_BASE | L`. The default `TT_BASE` is 9'h040, with the level in bits 3..0.
- R6: If `trap_lvl` is nonzero and `svc_tt` is greater than the candidate code, both outputs keep their values. If `svc_tt` equals the candidate, or `trap_lvl` is 0, the candidate is raised.
- R7: With `int_en`=0, an outstanding request is withdrawn (`irq_req` 0, `irq_tt` 0). With no request outstanding, both outputs stay unchanged.
- R8: A request is raised only when the candidate code differs from `irq_tt`. If the candidate equals `irq_tt`, the outputs are held.
- R9: `irq_req` and `irq_tt` are registered and reflect the inputs present at the previous rising clock edge.
- R10: `core_wake` is 1 for exactly the cycle after a clock edge at which some `ext_req` bit was 1 while it had been 0 at the edge before. A falling line or a steady line gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 16 | External interrupt request lines, one per level |
| soft_reg | input | 17 | Software interrupt register (bit 0 tick match, bit 16 system tick match) |
| cur_level | input | 4 | Current processor interrupt level threshold |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| svc_tt | input | 9 | Trap type now in service |
| irq_req | output | 1 | Interrupt request to the core |
| irq_tt | output | 9 | Trap type code of the requested interrupt |
| core_wake | output | 1 | One-cycle wake pulse on any rising external line |

## Verification
Two functions can act in the same cycle: the wake pulse, and the withdrawal of a request by the threshold rule. To make them coincide, the bench raises an external line at a level that is at or below `cur_level` while a request is outstanding. It then expects `core_wake`=1 together with `irq_req`=0 and `irq_tt`=0 on the same cycle. The bench also lines up a trap-type suppression with a rising edge, and expects the outputs to be held while the wake pulse still fires. Expected values come from a cycle model in the bench and are queued by the driver. A monitor compares them after each clock edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic [1:0] {
      ARB_HOLD  = 2'd0,
      ARB_CLEAR = 2'd1,
      ARB_RAISE = 2'd2
   } arb_act_e;

endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
   parameter int NUM_LEVELS = 16,
   parameter int SW_W       = 17,
   parameter int TICK_BIT   = 0,
   parameter int STICK_BIT  = 16,
   parameter int FOLD_LEVEL = 14
) (
   input  logic [NUM_LEVELS-1:0] ext_req,
   input  logic [SW_W-1:0]       soft_reg,
   output logic [NUM_LEVELS-1:0] pend
);

   logic timer_hit;
   assign timer_hit = soft_reg[TICK_BIT] | soft_reg[STICK_BIT];

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      logic soft_part;
      logic fold_part;
      if (g < SW_W && g != TICK_BIT && g != STICK_BIT) begin : g_soft
         assign soft_part = soft_reg[g];
      end else begin : g_nosoft
         assign soft_part = 1'b0;
      end
      if (g == FOLD_LEVEL) begin : g_fold
         assign fold_part = timer_hit;
      end else begin : g_nofold
         assign fold_part = 1'b0;
      end
      assign pend[g] = ext_req[g] | soft_part | fold_part;
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NUM_LEVELS = 16,
   parameter int LVL_W      = 4
) (
   input  logic [NUM_LEVELS-1:0] pend,
   input  logic [LVL_W-1:0]      thr,
   output logic                  any_above,
   output logic [LVL_W-1:0]      win_level
);

   logic [NUM_LEVELS-1:0] above;

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_mask
      assign above[g] = pend[g] && (LVL_W'(g) > thr);
   end

   assign any_above = |above;

   always_comb begin
      win_level = '0;
      for (int i = 0; i < NUM_LEVELS; i++) begin
         if (above[i]) win_level = LVL_W'(i);
      end
   end

endmodule

// File: rtl/irq_wake_detect.sv
module irq_wake_detect #(
   parameter int NUM_LEVELS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] ext_req,
   output logic                  core_wake
);

   logic [NUM_LEVELS-1:0] prev_q;
   logic                  wake_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         wake_q <= 1'b0;
      end else begin
         prev_q <= ext_req;
         wake_q <= |(ext_req & ~prev_q);
      end
   end

   assign core_wake = wake_q;

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
   parameter int NUM_LEVELS = 16,
   parameter int SW_W       = 17,
   parameter int TICK_BIT   = 0,
   parameter int STICK_BIT  = 16,
   parameter int FOLD_LEVEL = 14,
   parameter int TT_W       = 9,
   parameter int TL_W       = 3,
   parameter logic [8:0] TT_BASE = 9'h040,
   localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] ext_req,
   input  logic [SW_W-1:0]       soft_reg,
   input  logic [LVL_W-1:0]      cur_level,
   input  logic                  int_en,
   input  logic [TL_W-1:0]       trap_lvl,
   input  logic [TT_W-1:0]       svc_tt,
   output logic                  irq_req,
   output logic [TT_W-1:0]       irq_tt,
   output logic                  core_wake
);
   import irq_arb_pkg::*;

   localparam logic [TT_W-1:0] BASE_CODE = TT_W'(TT_BASE);

   initial begin
      assert (NUM_LEVELS == (1 << LVL_W))
         else $error("NUM_LEVELS must be a power of two");
      assert (FOLD_LEVEL < NUM_LEVELS && FOLD_LEVEL > 0)
         else $error("FOLD_LEVEL out of range");
      assert (TT_W > LVL_W) else $error("TT_W too narrow");
      assert (SW_W > TICK_BIT && SW_W > STICK_BIT)
         else $error("timer bits outside software register");
      assert (BASE_CODE[LVL_W-1:0] == '0)
         else $error("TT_BASE low bits must be zero");
   end

   logic [NUM_LEVELS-1:0] pend;
   logic                  any_above;
   logic [LVL_W-1:0]      win_level;
   logic [TT_W-1:0]       cand_tt;
   logic                  nested_block;
   arb_act_e              act;
   logic                  req_q;
   logic [TT_W-1:0]       tt_q;

   irq_pend_merge #(
      .NUM_LEVELS (NUM_LEVELS),
      .SW_W       (SW_W),
      .TICK_BIT   (TICK_BIT),
      .STICK_BIT  (STICK_BIT),
      .FOLD_LEVEL (FOLD_LEVEL)
   ) u_merge (
      .ext_req  (ext_req),
      .soft_reg (soft_reg),
      .pend     (pend)
   );

   irq_prio_pick #(
      .NUM_LEVELS (NUM_LEVELS),
      .LVL_W      (LVL_W)
   ) u_pick (
      .pend      (pend),
      .thr       (cur_level),
      .any_above (any_above),
      .win_level (win_level)
   );

   irq_wake_detect #(
      .NUM_LEVELS (NUM_LEVELS)
   ) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_req   (ext_req),
      .core_wake (core_wake)
   );

   assign cand_tt      = BASE_CODE | TT_W'(win_level);
   assign nested_block = (trap_lvl != '0) && (svc_tt > cand_tt);

   always_comb begin
      if (!any_above) begin
         act = ARB_CLEAR;
      end else if (!int_en) begin
         act = req_q ? ARB_CLEAR : ARB_HOLD;
      end else if (nested_block) begin
         act = ARB_HOLD;
      end else if (cand_tt != tt_q) begin
         act = ARB_RAISE;
      end else begin
         act = ARB_HOLD;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         tt_q  <= '0;
      end else begin
         case (act)
            ARB_CLEAR: begin
               req_q <= 1'b0;
               tt_q  <= '0;
            end
            ARB_RAISE: begin
               req_q <= 1'b1;
               tt_q  <= cand_tt;
            end
            default: begin
               req_q <= req_q;
               tt_q  <= tt_q;
            end
         endcase
      end
   end

   assign irq_req = req_q;
   assign irq_tt  = tt_q;

endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
   parameter int NUM_LEVELS = 16,
   parameter int SW_W       = 17,
   parameter int TT_W       = 9,
   parameter int TL_W       = 3,
   parameter int LVL_W      = 4,
   parameter logic [8:0] TT_BASE = 9'h040
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_LEVELS-1:0] ext_req,
   input logic [SW_W-1:0]       soft_reg,
   input logic                  int_en,
   input logic                  irq_req,
   input logic [TT_W-1:0]       irq_tt,
   input logic                  core_wake
);

   localparam logic [TT_W-1:0] BASE_CODE = TT_W'(TT_BASE);

   logic [NUM_LEVELS-1:0] seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= '0;
      else        seen_q <= ext_req;
   end

   // R4: nothing pending at all withdraws any request
   assert_idle_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req == '0 && soft_reg == '0) |=> (!irq_req && irq_tt == '0));

   // R7: disabled interrupts withdraw an outstanding request
   assert_disable_withdraws_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_en && irq_req) |=> (!irq_req && irq_tt == '0));

   // R5: an outstanding request always carries the base code
   assert_tt_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_tt[TT_W-1:LVL_W] == BASE_CODE[TT_W-1:LVL_W]));

   // R9: a new request only follows an enabled edge
   assert_raise_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $past(int_en));

   // R10: only falling lines never wake the core
   assert_fall_no_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((seen_q & ~ext_req) != '0 && (ext_req & ~seen_q) == '0) |=> !core_wake);

endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
   .NUM_LEVELS (NUM_LEVELS),
   .SW_W       (SW_W),
   .TT_W       (TT_W),
   .TL_W       (TL_W),
   .LVL_W      (LVL_W),
   .TT_BASE    (TT_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ext_req   (ext_req),
   .soft_reg  (soft_reg),
   .int_en    (int_en),
   .irq_req   (irq_req),
   .irq_tt    (irq_tt),
   .core_wake (core_wake)
);

// File: tb/sim_irq_level_arbiter.sv
`timescale 1ns/1ps
module sim_irq_level_arbiter;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] ext_req;
   logic [16:0] soft_reg;
   logic [3:0]  cur_level;
   logic        int_en;
   logic [2:0]  trap_lvl;
   logic [8:0]  svc_tt;
   logic        irq_req;
   logic [8:0]  irq_tt;
   logic        core_wake;

   always #4 clk = ~clk;

   irq_level_arbiter u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_req   (ext_req),
      .soft_reg  (soft_reg),
      .cur_level (cur_level),
      .int_en    (int_en),
      .trap_lvl  (trap_lvl),
      .svc_tt    (svc_tt),
      .irq_req   (irq_req),
      .irq_tt    (irq_tt),
      .core_wake (core_wake)
   );

   typedef struct {
      logic       req;
      logic [8:0] tt;
      logic       wake;
      string      tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_chk  = 0;
   int          n_fail = 0;
   logic        m_req  = 1'b0;
   logic [8:0]  m_tt   = '0;
   logic [15:0] m_prev = '0;

   task automatic check(input string tag, input logic ok, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // monitor: compares shortly after each edge
   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(e.tag, irq_req === e.req, "irq_req", int'(irq_req), int'(e.req));
         check(e.tag, irq_tt === e.tt, "irq_tt", int'(irq_tt), int'(e.tt));
         check(e.tag, core_wake === e.wake, "core_wake", int'(core_wake), int'(e.wake));
      end
   end

   task automatic drive(input logic [15:0] ex, input logic [16:0] sw,
                        input logic [3:0] lvl, input logic en,
                        input logic [2:0] tl, input logic [8:0] stt,
                        input string tag);
      logic [15:0] pm;
      logic        found;
      int          win;
      logic [8:0]  cand;
      exp_t        e;
      @(negedge clk);
      ext_req = ex; soft_reg = sw; cur_level = lvl;
      int_en = en; trap_lvl = tl; svc_tt = stt;
      for (int lv = 0; lv < 16; lv++)
         pm[lv] = ex[lv] | ((lv >= 1) ? sw[lv] : 1'b0);
      if (sw[0] || sw[16]) pm[14] = 1'b1;
      found = 1'b0; win = 0;
      for (int lv = 15; lv >= 0; lv--)
         if (!found && pm[lv] && lv > int'(lvl)) begin
            found = 1'b1; win = lv;
         end
      cand = 9'h040 | 9'(win);
      if (!found) begin
         m_req = 1'b0; m_tt = '0;
      end else if (!en) begin
         if (m_req) begin m_req = 1'b0; m_tt = '0; end
      end else if (tl != 0 && stt > cand) begin
         // held
      end else if (cand != m_tt) begin
         m_req = 1'b1; m_tt = cand;
      end
      e.req  = m_req;
      e.tt   = m_tt;
      e.wake = |(ex & ~m_prev);
      e.tag  = tag;
      m_prev = ex;
      sb_q.push_back(e);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      ext_req = '0; soft_reg = '0; cur_level = '0;
      int_en = 1'b0; trap_lvl = '0; svc_tt = '0;
      repeat (3) @(posedge clk);
      #2;
      check("R1", irq_req === 1'b0, "irq_req", int'(irq_req), 0);
      check("R1", irq_tt === 9'h0, "irq_tt", int'(irq_tt), 0);
      check("R1", core_wake === 1'b0, "core_wake", int'(core_wake), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 / R5 / R9 basic raise from external line 5
      drive(16'h0020, '0, 4'd0, 1'b1, 3'd0, 9'h0, "R2_R9");
      // R2 software bit 9 only, external dropped
      drive(16'h0000, 17'h00200, 4'd0, 1'b1, 3'd0, 9'h0, "R2");
      // R3 tick-match folds to 14
      drive(16'h0000, 17'h00001, 4'd0, 1'b1, 3'd0, 9'h0, "R3");
      // R3 / R8 system tick match gives same code, held
      drive(16'h0000, 17'h10000, 4'd0, 1'b1, 3'd0, 9'h0, "R3_R8");
      // R4 threshold at 14 hides level 14
      drive(16'h0000, 17'h10000, 4'd14, 1'b1, 3'd0, 9'h0, "R4");
      // R4 level equal to threshold hidden, then one above visible
      drive(16'h0008, '0, 4'd3, 1'b1, 3'd0, 9'h0, "R4");
      drive(16'h0008, '0, 4'd2, 1'b1, 3'd0, 9'h0, "R4");
      // R5 priority among several
      drive(16'h8421, '0, 4'd0, 1'b1, 3'd0, 9'h0, "R5");
      drive(16'h8421, '0, 4'd15, 1'b1, 3'd0, 9'h0, "R4");
      // R5 walk of single levels
      for (int lv = 1; lv < 16; lv++)
         drive(16'(1 << lv), '0, 4'd0, 1'b1, 3'd0, 9'h0, "R5");
      drive(16'h0000, '0, 4'd0, 1'b1, 3'd0, 9'h0, "R4");
      // R6 nested suppression with rising edge in same cycle
      drive(16'h0400, '0, 4'd0, 1'b1, 3'd1, 9'h04F, "R6_R10");
      drive(16'h0400, '0, 4'd0, 1'b1, 3'd1, 9'h04A, "R6");
      drive(16'h0800, '0, 4'd0, 1'b1, 3'd0, 9'h1FF, "R6");
      // R7 disabled withdraws, then stays quiet
      drive(16'h0800, '0, 4'd0, 1'b0, 3'd0, 9'h0, "R7");
      drive(16'h0800, '0, 4'd0, 1'b0, 3'd0, 9'h0, "R7");
      // R10 falling line does not wake, steady line does not wake
      drive(16'h0000, '0, 4'd0, 1'b0, 3'd0, 9'h0, "R10");
      drive(16'h0002, '0, 4'd0, 1'b0, 3'd0, 9'h0, "R10");
      drive(16'h0002, '0, 4'd0, 1'b0, 3'd0, 9'h0, "R10");
      // wake and threshold withdraw in the same cycle
      drive(16'h0202, '0, 4'd0, 1'b1, 3'd0, 9'h0, "R5");
      drive(16'h0206, '0, 4'd9, 1'b1, 3'd0, 9'h0, "R4_R10");
      drive(16'h0000, '0, 4'd0, 1'b1, 3'd0, 9'h0, "R10");
      @(negedge clk);
      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule